// File: doc/BRIEF.md
# Charge, Energy and Elapsed-Time Integrator

This block sums signed current and power samples, one sample per finished measurement cycle, into six saturating accumulators: three for charge and three for energy. It also counts the integration time in four time counters. Each accumulator has its own 2-bit mode. The mode can enable the accumulator, disable it, or make it conditional on the sign of the paired current sample and on whether that sample's magnitude is outside a per-channel deadband. In that way one register can collect only charge-in and another only discharge. Channel 1 samples feed charge 1, energy 1 and charge 3. Channel 2 samples feed charge 2, energy 2 and energy 3.

The accumulators do not wrap. They stop at the representable limits. Each accumulator raises a sticky warning once its magnitude reaches 90 % of full scale. Accumulation goes on after the warning. The host clears all accumulators, counters and warnings with one clear strobe.

Top module: `cet_accum`

## Requirements
- R1: After reset, every charge, energy and time register reads zero and all ten warning bits are low.
- R2: A register changes only in the cycle that follows a cycle with `smp_vld` high. In mode 01 (always), a charge register adds its channel's current and an energy register adds its channel's power.
- R3: In mode 00 (off), a register keeps its value whatever samples arrive.
- R4: In mode 10 (charging), the sample is added only when the current is strictly greater than the channel's deadband value.
- R5: In mode 11 (discharging), the sample is added only when the current is strictly less than the negated deadband value.
- R6: The time counters advance by one on each valid sample. Counter 1 advances when charge 1 or energy 1 accumulated, counter 2 when charge 2 or energy 2 accumulated, counter 3 when charge 3 accumulated, and counter 4 when energy 3 accumulated.
- R7: Signed accumulators saturate at +(2^(AW-1)-1) and at -2^(AW-1). Time counters saturate at 2^TW-1. Nothing wraps.
- R8: A warning bit sets when an accumulated value's magnitude reaches floor(0.9 × positive full scale). The bit stays set until a clear, and accumulation continues. The bit order in `warn_q` is [2:0] charge 1-3, [5:3] energy 1-3 and [9:6] time 1-4.
- R9: `clr` zeros every register and warning in the next cycle. It takes priority over a sample presented in the same cycle.
- R10: Mode fields sit in `mode_cfg` as [1:0] charge 1, [3:2] charge 2, [5:4] charge 3, [7:6] energy 1, [9:8] energy 2 and [11:10] energy 3. Charge 1, energy 1 and charge 3 are gated by channel 1 current. The other three registers are gated by channel 2 current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Host clear strobe |
| smp_vld | input | 1 | New sample set present |
| cur1 | input | DW | Channel 1 current, signed |
| cur2 | input | DW | Channel 2 current, signed |
| pwr1 | input | DW | Channel 1 power, signed |
| pwr2 | input | DW | Channel 2 power, signed |
| mode_cfg | input | 12 | Six 2-bit accumulation modes |
| dband1 | input | DW-1 | Channel 1 deadband magnitude |
| dband2 | input | DW-1 | Channel 2 deadband magnitude |
| chg_q | output | 3*AW | Charge registers, slot k at [k*AW +: AW] |
| nrg_q | output | 3*AW | Energy registers, slot k at [k*AW +: AW] |
| tim_q | output | 4*TW | Time counters, slot k at [k*TW +: TW] |
| warn_q | output | 10 | Near-overflow warnings |

## Verification
The assertions assume a synchronous reset and assume that `clr` and `smp_vld` may arrive together in any pattern. They also assume a deadband that is unsigned and at most half the sample range, so that negating it always fits. The bench drives every mode code, deadband values sitting exactly on and one step past the threshold, and full-scale samples of both signs held long enough to reach the guard level and then saturation. It also runs a random phase with occasional clears overlapping samples. Every input changes only on the falling clock edge, so each sample is seen whole at the rising edge.

// File: rtl/cet_pkg.sv
package cet_pkg;
   typedef enum logic [1:0] {
      ACC_OFF = 2'b00,
      ACC_ON  = 2'b01,
      ACC_POS = 2'b10,
      ACC_NEG = 2'b11
   } acc_mode_e;

   localparam int N_CHG  = 3;
   localparam int N_NRG  = 3;
   localparam int N_ACC  = N_CHG + N_NRG;
   localparam int N_TIM  = 4;
   localparam int N_WARN = N_ACC + N_TIM;
   localparam int MODE_W = 2;
endpackage

// File: rtl/cet_gate.sv
module cet_gate #(
   parameter int DW = 16
) (
   input  cet_pkg::acc_mode_e     mode,
   input  logic signed [DW-1:0]   cur,
   input  logic [DW-2:0]          dband,
   output logic                   fire
);
   import cet_pkg::*;

   if (DW < 4) begin : g_bad_dw
      $error("cet_gate: DW must be at least 4");
   end

   logic signed [DW:0] cur_x;
   logic signed [DW:0] db_pos;
   logic signed [DW:0] db_neg;

   always_comb begin
      cur_x  = {cur[DW-1], cur};
      db_pos = $signed({2'b00, dband});
      db_neg = -db_pos;
      unique case (mode)
         ACC_OFF: fire = 1'b0;
         ACC_ON:  fire = 1'b1;
         ACC_POS: fire = (cur_x > db_pos);
         ACC_NEG: fire = (cur_x < db_neg);
         default: fire = 1'b0;
      endcase
   end
endmodule

// File: rtl/cet_sat_acc.sv
module cet_sat_acc #(
   parameter int W      = 32,
   parameter int IW     = 16,
   parameter bit SIGNED = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          en,
   input  logic [IW-1:0] inc,
   output logic [W-1:0]  q,
   output logic          warn
);
   if (IW > W || W > 56 || W < 4 || IW < 1) begin : g_bad_w
      $error("cet_sat_acc: need 1 <= IW <= W and 4 <= W <= 56");
   end

   localparam logic [W-1:0] ONE_W = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] nxt;
   logic [W-1:0] mag;
   logic         hit;

   if (SIGNED) begin : g_sgn
      localparam logic [63:0]  FULL  = (64'd1 << (W-1)) - 64'd1;
      localparam logic [W-1:0] GUARD = W'((FULL * 64'd9) / 64'd10);
      logic [W:0] sum;
      always_comb begin
         sum = {q[W-1], q} + {{(W+1-IW){inc[IW-1]}}, inc};
         if (sum[W] != sum[W-1])
            nxt = sum[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
         else
            nxt = sum[W-1:0];
         mag = nxt[W-1] ? (~nxt + ONE_W) : nxt;
         hit = (mag >= GUARD);
      end

      AST_NO_WRAP_POS: assert property (@(posedge clk) disable iff (!rst_n)
         (en && !clr && !q[W-1] && !inc[IW-1]) |=> !q[W-1]) else $error("wrap"); // R7
      AST_NO_WRAP_NEG: assert property (@(posedge clk) disable iff (!rst_n)
         (en && !clr && q[W-1] && inc[IW-1]) |=> q[W-1]) else $error("wrap"); // R7
   end else begin : g_uns
      localparam logic [63:0]  FULL  = (64'd1 << W) - 64'd1;
      localparam logic [W-1:0] GUARD = W'((FULL * 64'd9) / 64'd10);
      logic [W:0] sum;
      always_comb begin
         sum = {1'b0, q} + {{(W+1-IW){1'b0}}, inc};
         nxt = sum[W] ? {W{1'b1}} : sum[W-1:0];
         mag = nxt;
         hit = (mag >= GUARD);
      end

      AST_NO_WRAP_CNT: assert property (@(posedge clk) disable iff (!rst_n)
         (en && !clr) |=> (q >= $past(q))) else $error("wrap"); // R7
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q    <= '0;
         warn <= 1'b0;
      end else if (clr) begin
         q    <= '0;
         warn <= 1'b0;
      end else if (en) begin
         q <= nxt;
         if (hit) warn <= 1'b1;
      end
   end

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) |=> $stable(q)) else $error("hold"); // R3
   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (q == '0 && !warn)) else $error("clear"); // R9
   AST_WARN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (warn && !clr) |=> warn) else $error("sticky"); // R8
endmodule

// File: rtl/cet_accum.sv
module cet_accum #(
   parameter int DW = 16,
   parameter int AW = 40,
   parameter int TW = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 smp_vld,
   input  logic signed [DW-1:0] cur1,
   input  logic signed [DW-1:0] cur2,
   input  logic signed [DW-1:0] pwr1,
   input  logic signed [DW-1:0] pwr2,
   input  logic [11:0]          mode_cfg,
   input  logic [DW-2:0]        dband1,
   input  logic [DW-2:0]        dband2,
   output logic [3*AW-1:0]      chg_q,
   output logic [3*AW-1:0]      nrg_q,
   output logic [4*TW-1:0]      tim_q,
   output logic [9:0]           warn_q
);
   import cet_pkg::*;

   localparam logic [N_ACC-1:0] ON_CH2  = 6'b110010;
   localparam logic [N_ACC-1:0] PWR_CH2 = 6'b110000;

   if (AW < DW) begin : g_bad_aw
      $error("cet_accum: AW must not be narrower than DW");
   end
   if (N_ACC * MODE_W != 12) begin : g_bad_mode
      $error("cet_accum: mode field layout mismatch");
   end

   logic [N_ACC-1:0] fire;
   logic [N_ACC-1:0] acc_en;
   logic [N_ACC-1:0] acc_warn;
   logic [AW-1:0]    acc_q [N_ACC];
   logic [N_TIM-1:0] tim_en;
   logic [N_TIM-1:0] tim_warn;
   logic [TW-1:0]    tim_v [N_TIM];

   for (genvar k = 0; k < N_ACC; k++) begin : g_acc
      logic signed [DW-1:0] gate_cur;
      logic [DW-2:0]        gate_db;
      logic [DW-1:0]        addend;

      assign gate_cur = ON_CH2[k] ? cur2 : cur1;
      assign gate_db  = ON_CH2[k] ? dband2 : dband1;

      if (k < N_CHG) begin : g_chg
         assign addend = gate_cur;
      end else begin : g_nrg
         assign addend = PWR_CH2[k] ? pwr2 : pwr1;
      end

      cet_gate #(.DW(DW)) u_gate (
         .mode  (acc_mode_e'(mode_cfg[MODE_W*k +: MODE_W])),
         .cur   (gate_cur),
         .dband (gate_db),
         .fire  (fire[k])
      );

      assign acc_en[k] = smp_vld && fire[k];

      cet_sat_acc #(.W(AW), .IW(DW), .SIGNED(1'b1)) u_acc (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (clr),
         .en    (acc_en[k]),
         .inc   (addend),
         .q     (acc_q[k]),
         .warn  (acc_warn[k])
      );
   end

   // time pairing: set 1 and set 2 share a counter; extra charge and energy each own one
   assign tim_en[0] = acc_en[0] | acc_en[3];
   assign tim_en[1] = acc_en[1] | acc_en[4];
   assign tim_en[2] = acc_en[2];
   assign tim_en[3] = acc_en[5];

   for (genvar t = 0; t < N_TIM; t++) begin : g_tim
      cet_sat_acc #(.W(TW), .IW(1), .SIGNED(1'b0)) u_tim (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (clr),
         .en    (tim_en[t]),
         .inc   (1'b1),
         .q     (tim_v[t]),
         .warn  (tim_warn[t])
      );
      assign tim_q[t*TW +: TW] = tim_v[t];

      AST_TIME_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
         !clr |=> (tim_q[t*TW +: TW] >= $past(tim_q[t*TW +: TW]))) else $error("time"); // R6
   end

   for (genvar c = 0; c < N_CHG; c++) begin : g_out
      assign chg_q[c*AW +: AW] = acc_q[c];
      assign nrg_q[c*AW +: AW] = acc_q[N_CHG + c];
   end

   assign warn_q = {tim_warn, acc_warn};

   AST_NO_SAMPLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_vld && !clr) |=> ($stable(chg_q) && $stable(nrg_q) && $stable(tim_q))) else $error("idle"); // R2
   AST_TIME_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && smp_vld) |=> (tim_q[TW-1:0] - $past(tim_q[TW-1:0]) <= TW'(1))) else $error("step"); // R6
endmodule

// File: tb/cet_accum_test.sv
module cet_accum_test;
   localparam int DW = 16;
   localparam int AW = 20;
   localparam int TW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr = 1'b0;
   logic vld = 1'b0;
   logic signed [DW-1:0] c1 = '0, c2 = '0, p1 = '0, p2 = '0;
   logic [11:0] mode = '0;
   logic [DW-2:0] db1 = '0, db2 = '0;
   logic [3*AW-1:0] chg_q, nrg_q;
   logic [4*TW-1:0] tim_q;
   logic [9:0] warn_q;

   int checks = 0;
   int fails = 0;
   string req_tag = "R1";

   always #10 clk = ~clk;

   cet_accum #(.DW(DW), .AW(AW), .TW(TW)) uut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .smp_vld(vld),
      .cur1(c1), .cur2(c2), .pwr1(p1), .pwr2(p2),
      .mode_cfg(mode), .dband1(db1), .dband2(db2),
      .chg_q(chg_q), .nrg_q(nrg_q), .tim_q(tim_q), .warn_q(warn_q)
   );

   // behavioural reference model
   longint acc_m [6];
   longint tim_m [4];
   bit     warn_m [10];
   longint amax, amin, aguard, tmax, tguard;

   initial begin
      amax   = (longint'(1) <<< (AW-1)) - 1;
      amin   = -amax - 1;
      aguard = (amax * 9) / 10;
      tmax   = (longint'(1) <<< TW) - 1;
      tguard = (tmax * 9) / 10;
   end

   function automatic bit decide(int m, longint cur, longint db);
      case (m)
         0: return 1'b0;
         1: return 1'b1;
         2: return cur > db;
         default: return cur < -db;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n || clr) begin
         foreach (acc_m[i]) acc_m[i] = 0;
         foreach (tim_m[i]) tim_m[i] = 0;
         foreach (warn_m[i]) warn_m[i] = 0;
      end else if (vld) begin
         bit f [6];
         bit tf [4];
         for (int k = 0; k < 6; k++) begin
            longint cur, db, add, v;
            bit ch2;
            ch2 = (k == 1 || k == 4 || k == 5);
            cur = ch2 ? longint'(c2) : longint'(c1);
            db  = ch2 ? longint'(db2) : longint'(db1);
            if (k < 3) add = cur;
            else add = ch2 ? longint'(p2) : longint'(p1);
            f[k] = decide(int'(mode[2*k +: 2]), cur, db);
            if (f[k]) begin
               v = acc_m[k] + add;
               if (v > amax) v = amax;
               if (v < amin) v = amin;
               acc_m[k] = v;
               if (v >= aguard || v <= -aguard) warn_m[k] = 1;
            end
         end
         tf[0] = f[0] | f[3];
         tf[1] = f[1] | f[4];
         tf[2] = f[2];
         tf[3] = f[5];
         for (int t = 0; t < 4; t++) begin
            if (tf[t]) begin
               if (tim_m[t] < tmax) tim_m[t] = tim_m[t] + 1;
               if (tim_m[t] >= tguard) warn_m[6+t] = 1;
            end
         end
      end
   end

   task automatic chk(string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req_tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         for (int k = 0; k < 3; k++) begin
            chk($sformatf("charge%0d", k+1), longint'($signed(chg_q[k*AW +: AW])), acc_m[k]);
            chk($sformatf("energy%0d", k+1), longint'($signed(nrg_q[k*AW +: AW])), acc_m[3+k]);
         end
         for (int t = 0; t < 4; t++)
            chk($sformatf("time%0d", t+1), longint'(tim_q[t*TW +: TW]), tim_m[t]);
         for (int w = 0; w < 10; w++)
            chk($sformatf("warn[%0d]", w), longint'(warn_q[w]), longint'(warn_m[w]));
      end
   end

   task automatic step(bit v, int a1, int a2, int b1, int b2);
      @(negedge clk);
      vld = v;
      c1 = DW'(a1); c2 = DW'(a2); p1 = DW'(b1); p2 = DW'(b2);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      req_tag = "R1";
      step(0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0);

      // R2 / R10: all registers always on
      req_tag = "R2";
      mode = 12'h555;
      step(1, 100, -50, 200, -300);
      step(1, -1000, 2000, 7, -7);
      step(1, 32767, -32768, 0, 5);
      // R2: no sample, inputs wiggle
      step(0, 999, 999, 999, 999);
      step(0, -5, 5, -5, 5);

      // R3: charge 1 off, others on
      req_tag = "R3";
      mode = 12'h554;
      step(1, 400, 1, 2, 3);
      step(1, -700, 4, 5, 6);

      // R4: charging-only with deadband boundary
      req_tag = "R4";
      mode = 12'hAAA; db1 = 15'd100; db2 = 15'd5;
      step(1, 100, 5, 11, 12);
      step(1, 101, 6, 13, 14);
      step(1, -200, -6, 15, 16);

      // R5: discharging-only with deadband boundary
      req_tag = "R5";
      mode = 12'hFFF;
      step(1, -100, -5, 21, 22);
      step(1, -101, -6, 23, 24);
      step(1, 300, 6, 25, 26);

      // R6: mixed enables exercise the time pairing
      req_tag = "R6";
      mode = 12'h501; db1 = '0; db2 = '0;
      step(1, 10, 20, 30, 40);
      step(1, -3, 8, -9, 11);
      mode = 12'h010;
      step(1, 1, 1, 1, 1);
      step(0, 0, 0, 0, 0);

      // R9: clear with concurrent sample, then alone
      req_tag = "R9";
      mode = 12'h555;
      @(negedge clk); clr = 1'b1; vld = 1'b1; c1 = 16'sd50;
      @(negedge clk); clr = 1'b0; vld = 1'b0;
      step(1, 9, 9, 9, 9);
      @(negedge clk); clr = 1'b1; vld = 1'b0;
      @(negedge clk); clr = 1'b0;

      // R7 / R8: drive to guard then saturation in both directions
      req_tag = "R7";
      for (int i = 0; i < 24; i++) step(1, 32767, -32768, 32767, -32768);
      req_tag = "R8";
      step(1, -100, 100, -100, 100);
      step(1, -32768, 32767, 0, 0);
      @(negedge clk); clr = 1'b1; vld = 1'b0;
      @(negedge clk); clr = 1'b0;

      // R6 / R7: time counters reach guard and saturate
      req_tag = "R6";
      for (int i = 0; i < 300; i++) step(1, 1, 1, 1, 1);
      step(0, 0, 0, 0, 0);

      // R10: random modes, deadbands, samples and sparse clears
      req_tag = "R10";
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (i % 16 == 0) begin
            mode = 12'($urandom);
            db1  = 15'($urandom_range(0, 300));
            db2  = 15'($urandom_range(0, 300));
         end
         clr = ($urandom_range(0, 40) == 0);
         vld = ($urandom_range(0, 3) != 0);
         c1 = 16'($urandom_range(0, 1000)) - 16'sd500;
         c2 = 16'($urandom_range(0, 1000)) - 16'sd500;
         p1 = 16'($urandom);
         p2 = 16'($urandom);
      end
      @(negedge clk); clr = 1'b0; vld = 1'b0;
      @(negedge clk);
      finish_run();
   end
endmodule